// File: doc/BRIEF.md
# Glitch-free selectable clock divider

The block derives an output clock from a core clock `clk`. A two-bit select input picks one of four ratios, and an enable input starts and stops the output. All output edges land on rising edges of `clk`, and `clk_out` is a registered signal.

The output half-period is 1, 2, 4 or 8 core cycles. Ratio 1 is the undivided setting: one full output period lasts two core cycles, which is one reference period when `clk` runs at twice the reference rate. In every ratio the high and low phases have the same length.

The select may change while the output runs. Both the select and the enable pass through a synchroniser first. A new ratio is applied only where a low phase ends, and that low phase is stretched to a minimum length before the first high phase at the new ratio begins. The last pulse at the old ratio and the first pulse at the new ratio therefore both have their full width, and no short pulse appears. A clear enable forces the output low. Setting enable starts the output with a full high phase.

Top module: `clk_sel_div`

## Requirements
- R1: A synchronous active-high `rst` drives `clk_out` low on the next rising edge. It also clears the synchroniser, so after reset the active ratio is the one for select code 00.
- R2: Select codes map to output half-periods in core cycles: 2'b10 gives 1, 2'b11 gives 2, 2'b01 gives 4 and 2'b00 gives 8.
- R3: While the select is steady and enable is high, each high phase and each low phase lasts exactly the half-period of the active ratio, so the duty cycle is 50%.
- R4: `sel` and `en` are each delayed through a SYNC_STAGES-deep register chain before they affect the output. A select pulse that the chain captures is treated as a real request.
- R5: A ratio change is applied only at a low-to-high output transition. The high phase in progress when the request arrives finishes at the old width.
- R6: When the synchronised select differs from the active ratio, the current low phase lasts MIN_SWITCH_LOW core cycles (default 16). The output then rises and runs a full high phase at the new ratio.
- R7: While the synchronised enable is low, `clk_out` is low from the following core cycle onward, even if this cuts a high phase short.
- R8: When the synchronised enable rises, `clk_out` goes high on the next edge. This first high phase has the full half-period of the ratio selected at that moment.
- R9: A select change made while disabled takes effect directly at the next start, with no stretched low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all output edges align to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run request; low forces the output low |
| sel | input | 2 | Ratio select code, changed one bit at a time |
| clk_out | output | 1 | Divided output clock, registered |

## Verification
The divider first runs steadily in each of the four ratios. This separates a wrong code mapping from a wrong phase counter, because the measured high and low widths must both equal the half-period. Ratio steps are then issued at every offset within a 16-cycle window. Some land in a high phase, some in an ordinary low phase and some inside a stretch already under way, so an early load, a missing stretch and a truncated last pulse each show up as a different cycle of disagreement. Further patterns cover a one-cycle select blip, a stop in the middle of a phase, a select change while stopped, and a reset during operation. These exercise the synchroniser latency and the start-up phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int SHIFT_W = 2;

  typedef logic [1:0]         ratio_code_t;
  typedef logic [SHIFT_W-1:0] ratio_shift_t;

  // log2 of the output half-period for each select code
  function automatic ratio_shift_t code_to_shift(input ratio_code_t code);
    ratio_shift_t s;
    case (code)
      2'b10:   s = 2'd0;
      2'b11:   s = 2'd1;
      2'b01:   s = 2'd2;
      default: s = 2'd3;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cdiv_sync.sv
module cdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cdiv_ratio_dec.sv
module cdiv_ratio_dec
  import clkdiv_pkg::*;
(
  input  ratio_code_t  code,
  output ratio_shift_t shift
);

  always_comb shift = code_to_shift(code);

endmodule

// File: rtl/cdiv_phase_gen.sv
module cdiv_phase_gen
  import clkdiv_pkg::*;
#(
  parameter int MIN_LOW = 16,
  parameter int RUN_W   = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_s,
  input  ratio_shift_t tgt_shift,
  output logic         out_q,
  output ratio_shift_t act_shift,
  output logic         running
);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] cur_half;
  logic [RUN_W-1:0] low_need;
  logic             pending;
  logic             hi_done;
  logic             lo_done;

  always_comb begin
    cur_half = RUN_W'(1) << act_shift;
    pending  = (tgt_shift != act_shift);
    low_need = pending ? RUN_W'(MIN_LOW) : cur_half;
    hi_done  = (run_q == cur_half - RUN_W'(1));
    lo_done  = (run_q >= low_need - RUN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q     <= 1'b0;
      running   <= 1'b0;
      run_q     <= '0;
      act_shift <= code_to_shift(2'b00);
    end else if (!en_s) begin
      out_q     <= 1'b0;
      running   <= 1'b0;
      run_q     <= '0;
      act_shift <= tgt_shift;
    end else if (!running) begin
      out_q     <= 1'b1;
      running   <= 1'b1;
      run_q     <= '0;
      act_shift <= tgt_shift;
    end else if (out_q) begin
      if (hi_done) begin
        out_q <= 1'b0;
        run_q <= '0;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end else begin
      if (lo_done) begin
        out_q     <= 1'b1;
        run_q     <= '0;
        act_shift <= tgt_shift;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end

endmodule

// File: rtl/clk_sel_div.sv
module clk_sel_div
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_SWITCH_LOW = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       clk_out
);

  localparam int RUN_W = $clog2(MIN_SWITCH_LOW + 1);

  logic [2:0]   sync_q;
  logic         en_s;
  ratio_code_t  sel_s;
  ratio_shift_t tgt_shift;
  ratio_shift_t act_shift;
  logic         running;

  cdiv_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({en, sel}),
    .q   (sync_q)
  );

  assign en_s  = sync_q[2];
  assign sel_s = sync_q[1:0];

  cdiv_ratio_dec u_dec (
    .code  (sel_s),
    .shift (tgt_shift)
  );

  cdiv_phase_gen #(.MIN_LOW(MIN_SWITCH_LOW), .RUN_W(RUN_W)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .en_s      (en_s),
    .tgt_shift (tgt_shift),
    .out_q     (clk_out),
    .act_shift (act_shift),
    .running   (running)
  );

endmodule

// File: rtl/clk_sel_div_chk.sv
module clk_sel_div_chk #(
  parameter int MIN_SWITCH_LOW = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       clk_out,
  input logic       en_s,
  input logic       running,
  input logic [1:0] act_shift
);

  logic       prev_q;
  logic [7:0] len_q;

  // length of the phase that ended at the last output change
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      len_q  <= '0;
    end else begin
      prev_q <= clk_out;
      if (clk_out != prev_q)  len_q <= 8'd1;
      else if (len_q != 8'hFF) len_q <= len_q + 8'd1;
    end
  end

  p_high_width_r3: assert property (@(posedge clk) disable iff (rst)
    (prev_q && !clk_out && $past(en_s) && $past(running)) |-> (len_q == (8'd1 << act_shift)));

  p_low_min_r5: assert property (@(posedge clk) disable iff (rst)
    (!prev_q && clk_out && $past(running) && (act_shift == $past(act_shift)))
      |-> (len_q >= (8'd1 << act_shift)));

  p_switch_stretch_r6: assert property (@(posedge clk) disable iff (rst)
    (!prev_q && clk_out && $past(running) && (act_shift != $past(act_shift)))
      |-> (len_q >= 8'(MIN_SWITCH_LOW)));

  p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> !clk_out);

  p_start_high_r8: assert property (@(posedge clk) disable iff (rst)
    (en_s && !running) |=> (clk_out && running));

endmodule

bind clk_sel_div clk_sel_div_chk #(.MIN_SWITCH_LOW(MIN_SWITCH_LOW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_out   (clk_out),
  .en_s      (en_s),
  .running   (running),
  .act_shift (act_shift)
);

// File: tb/tb_clk_sel_div.sv
`timescale 1ns/1ps
module tb_clk_sel_div;

  localparam int SYNC = 2;
  localparam int MINL = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       clk_out;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string cur_req = "R1";

  clk_sel_div #(.SYNC_STAGES(SYNC), .MIN_SWITCH_LOW(MINL)) dut (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .clk_out(clk_out)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  bit         q_en[$];
  logic [1:0] q_sel[$];
  bit         m_out = 0, m_running = 0;
  int         m_run = 0, m_half = 8;

  function automatic int half_of(input logic [1:0] c);
    case (c)
      2'b10:   return 1;
      2'b11:   return 2;
      2'b01:   return 4;
      default: return 8;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < SYNC; i++) begin q_en.push_back(0); q_sel.push_back(2'b00); end
  end

  always @(posedge clk) begin
    bit e; int h;
    if (rst) begin
      q_en.delete(); q_sel.delete();
      for (int i = 0; i < SYNC; i++) begin q_en.push_back(0); q_sel.push_back(2'b00); end
      m_out = 0; m_running = 0; m_run = 0; m_half = 8;
    end else begin
      e = q_en.pop_front();
      h = half_of(q_sel.pop_front());
      q_en.push_back(en);
      q_sel.push_back(sel);
      if (!e) begin
        m_out = 0; m_running = 0; m_run = 0; m_half = h;
      end else if (!m_running) begin
        m_out = 1; m_running = 1; m_run = 0; m_half = h;
      end else if (m_out) begin
        if (m_run + 1 >= m_half) begin m_out = 0; m_run = 0; end
        else m_run++;
      end else begin
        if (m_run + 1 >= ((h != m_half) ? MINL : m_half)) begin
          m_out = 1; m_run = 0; m_half = h;
        end else m_run++;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_cmp++;
      if (clk_out !== m_out) begin
        n_bad++;
        $display("FAIL %s: clk_out=%0b expected %0b at cycle %0d", cur_req, clk_out, m_out, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 200000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: clk_out=%0b expected %0b", req, act, exp);
    end
  endtask

  // measure one high phase and the following low phase
  task automatic measure(input int exp_half, input string req);
    int hi = 0, lo = 0, guard = 0;
    while (clk_out !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    while (clk_out === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    while (clk_out === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
    n_cmp++;
    if (hi != exp_half || lo != exp_half) begin
      n_bad++;
      $display("FAIL %s: high=%0d low=%0d expected %0d each", req, hi, lo, exp_half);
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    check_bit(clk_out, 1'b0, "R1");

    cur_req = "R8"; en = 1'b1; idle(4);
    cur_req = "R2"; idle(30); measure(8, "R2 code00");

    cur_req = "R6"; sel = 2'b01; idle(60);
    cur_req = "R3"; measure(4, "R3 code01");
    cur_req = "R5"; sel = 2'b11; idle(60); measure(2, "R2 code11");
    cur_req = "R6"; sel = 2'b10; idle(60); measure(1, "R2 code10");
    cur_req = "R6"; sel = 2'b00; idle(60); measure(8, "R3 code00");

    cur_req = "R5";
    for (int k = 0; k < 16; k++) begin
      idle(k);
      sel[0] = ~sel[0];
      idle(50);
    end

    cur_req = "R4"; sel = 2'b00; idle(60);
    sel = 2'b01; idle(1); sel = 2'b00; idle(60);

    cur_req = "R7"; idle(5); en = 1'b0; idle(SYNC + 1);
    check_bit(clk_out, 1'b0, "R7");
    idle(6); check_bit(clk_out, 1'b0, "R7");

    cur_req = "R9"; sel = 2'b01; idle(5);
    en = 1'b1;
    measure(4, "R9 start");
    idle(20);

    cur_req = "R1"; idle(3); rst = 1'b1; idle(1);
    check_bit(clk_out, 1'b0, "R1 reset");
    idle(2); rst = 1'b0;
    cur_req = "R8"; idle(40);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule